// File: doc/BRIEF.md
# External Event Timestamp Capture

This block records the time of day at which a chosen external event line changes level. A bank of raw, asynchronous event lines enters the block. Each line is first brought into the local clock domain. A six-bit select field then picks one line, and an edge detector watches it for either a rising or a falling edge. When an armed edge is seen, the block stores the seconds and nanoseconds from the time bus in one 64-bit word and raises a capture-valid flag.

Software, or a downstream agent, takes the word through a valid/ready output. The flag drops when the word is taken. Back-pressure does not stall capture. While the flag is high, a newer edge replaces the stored word and the flag stays high, so the word on offer is always the most recent capture. If a capture and a take fall in the same cycle, the new capture wins and the flag stays high. Both time fields are taken from the bus in the same clock cycle. A capture near a seconds rollover therefore never mixes the old seconds with the new nanoseconds.

Top module: `evt_stamp_capture`

## Requirements
- R1: While reset is asserted, and after it is released with no capture yet, `cap_valid` is 0 and `cap_data` is all zeros.
- R2: Configuration bit 8 arms capture (1 = armed). While it is 0, edges on any line cause no capture, and `cap_valid` and `cap_data` keep their values.
- R3: Configuration bit 9 picks the edge: 1 captures on a 0-to-1 change and 0 captures on a 1-to-0 change. An edge of the other direction causes no capture.
- R4: Configuration bits 15:10 give the index of the event line that is watched. Changes on any other line cause no capture. Configuration bits 7:0 have no effect.
- R5: The captured word holds seconds in bits 63:32 and nanoseconds in bits 31:0. Both fields come from the same clock cycle.
- R6: A level change on the watched line that is set up before clock edge E0 is captured at edge E2, with the time bus value present at E2. `cap_valid` and `cap_data` show the capture from E2 onward.
- R7: `cap_valid` rises on a capture. It falls on the edge where `cap_valid` and `cap_ready` are both 1 and no new capture occurs. Without that handshake, the flag and the word hold.
- R8: A capture while `cap_valid` is 1, including one in the same cycle as a handshake, replaces `cap_data` and leaves `cap_valid` at 1.
- R9: A change of the line select alone never causes a capture, even when the newly selected line's level differs from that of the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tod_sec | input | 32 | Time bus, seconds |
| tod_nsec | input | 32 | Time bus, nanoseconds |
| evt_in | input | 64 | Raw asynchronous event lines |
| cfg_word | input | 16 | Bit 8 arm, bit 9 edge polarity, bits 15:10 line select |
| cap_data | output | 64 | Captured time: seconds 63:32, nanoseconds 31:0 |
| cap_valid | output | 1 | A capture is held and on offer |
| cap_ready | input | 1 | The consumer takes the held capture this cycle |

## Verification
The in-RTL properties check the valid/ready rules on every cycle:
- a held word stays put until it is taken;
- a take with no competing capture clears the flag;
- every capture loads exactly the time bus value of its cycle;
- a disarmed block never raises the flag.

Only the bench scenarios can show the following, because they depend on the stimulus history:
- the two-edge synchronizer latency;
- the polarity and line selection;
- that switching the select between lines at different levels creates no capture;
- that a capture straddling a seconds rollover carries a consistent pair.

// File: rtl/evt_cap_pkg.sv
package evt_cap_pkg;
  localparam int CFG_W    = 16;
  localparam int ARM_BIT  = 8;
  localparam int POL_BIT  = 9;
  localparam int SEL_LSB  = 10;
  localparam int SEL_W    = 6;

  typedef struct packed {
    logic             arm;
    logic             rise;
    logic [SEL_W-1:0] sel;
  } evt_cfg_t;

  function automatic evt_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    evt_cfg_t c;
    c.arm  = w[ARM_BIT];
    c.rise = w[POL_BIT];
    c.sel  = w[SEL_LSB +: SEL_W];
    return c;
  endfunction
endpackage

// File: rtl/evt_sync_bank.sv
module evt_sync_bank #(
  parameter int N_LINES = 64,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] raw_in,
  output logic [N_LINES-1:0] lvl_now,
  output logic [N_LINES-1:0] lvl_prev
);
  localparam int CHAIN = STAGES + 1;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [CHAIN-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], raw_in[g]};
    end
    assign lvl_now[g]  = chain_q[STAGES-1];
    assign lvl_prev[g] = chain_q[STAGES];
  end
endmodule

// File: rtl/evt_edge_pick.sv
module evt_edge_pick
  import evt_cap_pkg::*;
#(
  parameter int N_LINES = 64
) (
  input  logic [N_LINES-1:0] lvl_now,
  input  logic [N_LINES-1:0] lvl_prev,
  input  evt_cfg_t           cfg,
  output logic               fire
);
  logic cur_b, old_b, in_range, rose, fell;

  always_comb begin
    in_range = (32'(cfg.sel) < N_LINES);
    cur_b    = 1'b0;
    old_b    = 1'b0;
    for (int i = 0; i < N_LINES; i++) begin
      if (32'(cfg.sel) == i) begin
        cur_b = lvl_now[i];
        old_b = lvl_prev[i];
      end
    end
    rose = cur_b & ~old_b;
    fell = ~cur_b & old_b;
    fire = cfg.arm & in_range & (cfg.rise ? rose : fell);
  end
endmodule

// File: rtl/evt_stamp_reg.sv
module evt_stamp_reg #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire,
  input  logic [SEC_W-1:0]      sec_in,
  input  logic [NS_W-1:0]       nsec_in,
  input  logic                  take,
  output logic [SEC_W+NS_W-1:0] word_q,
  output logic                  held_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      held_q <= 1'b0;
    end else if (fire) begin
      word_q <= {sec_in, nsec_in};
      held_q <= 1'b1;
    end else if (held_q && take) begin
      held_q <= 1'b0;
    end
  end

  // R7
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !take && !fire) |=> (held_q && $stable(word_q)));

  // R7
  clear_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && take && !fire) |=> !held_q);

  // R8
  load_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (held_q && word_q == $past({sec_in, nsec_in})));
endmodule

// File: rtl/evt_stamp_capture.sv
module evt_stamp_capture
  import evt_cap_pkg::*;
#(
  parameter int N_EVT       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int SEC_W       = 32,
  parameter int NS_W        = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEC_W-1:0]      tod_sec,
  input  logic [NS_W-1:0]       tod_nsec,
  input  logic [N_EVT-1:0]      evt_in,
  input  logic [CFG_W-1:0]      cfg_word,
  output logic [SEC_W+NS_W-1:0] cap_data,
  output logic                  cap_valid,
  input  logic                  cap_ready
);
  logic [N_EVT-1:0] lvl_now, lvl_prev;
  evt_cfg_t         cfg;
  logic             fire;

  assign cfg = decode_cfg(cfg_word);

  evt_sync_bank #(.N_LINES(N_EVT), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (evt_in),
    .lvl_now  (lvl_now),
    .lvl_prev (lvl_prev)
  );

  evt_edge_pick #(.N_LINES(N_EVT)) u_pick (
    .lvl_now  (lvl_now),
    .lvl_prev (lvl_prev),
    .cfg      (cfg),
    .fire     (fire)
  );

  evt_stamp_reg #(.SEC_W(SEC_W), .NS_W(NS_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .sec_in  (tod_sec),
    .nsec_in (tod_nsec),
    .take    (cap_ready),
    .word_q  (cap_data),
    .held_q  (cap_valid)
  );

  // R2
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_word[ARM_BIT] && !cap_valid) |=> !cap_valid);
endmodule

// File: tb/evt_stamp_capture_bench.sv
module evt_stamp_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tod_sec = 32'd0, tod_nsec = 32'd0;
  logic [63:0] evt_in = '0;
  logic [15:0] cfg_word = '0;
  logic [63:0] cap_data;
  logic        cap_valid;
  logic        cap_ready = 1'b0;

  int tests = 0, fails = 0;
  bit done = 0;

  // time bus driver, reloadable
  bit          ld_req = 0;
  logic [31:0] ld_sec, ld_nsec;

  // reference model state
  bit [63:0] hist[$] = '{64'd0, 64'd0, 64'd0, 64'd0};
  bit        m_valid = 0;
  bit [63:0] m_data = 0;

  always #5 clk = ~clk;

  evt_stamp_capture u_evt_stamp_capture (
    .clk(clk), .rst_n(rst_n), .tod_sec(tod_sec), .tod_nsec(tod_nsec),
    .evt_in(evt_in), .cfg_word(cfg_word), .cap_data(cap_data),
    .cap_valid(cap_valid), .cap_ready(cap_ready)
  );

  always @(negedge clk) begin
    if (ld_req) begin
      tod_sec = ld_sec; tod_nsec = ld_nsec; ld_req = 0;
    end else if (tod_nsec + 32'd7 >= 32'd1000000000) begin
      tod_nsec = tod_nsec + 32'd7 - 32'd1000000000;
      tod_sec  = tod_sec + 32'd1;
    end else begin
      tod_nsec = tod_nsec + 32'd7;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model: sampled raw history, capture uses samples two and three edges back
  always @(posedge clk) begin
    bit nb, ob, f;
    int s;
    if (!rst_n) begin
      hist = '{64'd0, 64'd0, 64'd0, 64'd0};
      m_valid = 0; m_data = 0;
    end else begin
      hist.push_back(evt_in);
      void'(hist.pop_front());
      s  = int'(cfg_word[15:10]);
      nb = hist[1][s];
      ob = hist[0][s];
      f  = cfg_word[8] && (cfg_word[9] ? (nb && !ob) : (!nb && ob));
      if (f) begin
        m_valid = 1; m_data = {tod_sec, tod_nsec};
      end else if (m_valid && cap_ready) begin
        m_valid = 0;
      end
    end
  end

  // per-cycle comparison against the model (R6, R7)
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(cap_valid == m_valid, "R7 model valid", {63'd0, cap_valid}, {63'd0, m_valid});
      chk(cap_data == m_data, "R6 model data", cap_data, m_data);
    end
  end

  // change one line, then return the time bus value that the capture edge E2 sees
  task automatic drive_and_stamp(input int line, input bit lvl, output logic [63:0] stamp);
    @(negedge clk); evt_in[line] = lvl;
    repeat (2) @(posedge clk);
    @(negedge clk); #1 stamp = {tod_sec, tod_nsec};
    @(posedge clk); @(negedge clk); #3;
  endtask

  task automatic take();
    @(negedge clk); cap_ready = 1;
    @(negedge clk); cap_ready = 0;
    #3;
  endtask

  function automatic logic [15:0] mk_cfg(bit arm, bit rise, int sel, logic [7:0] low);
    return {6'(sel), rise, arm, low};
  endfunction

  initial begin
    logic [63:0] st, st2, keep;
    repeat (3) @(negedge clk);
    #3;
    chk(cap_valid == 0, "R1 valid in reset", {63'd0, cap_valid}, 64'd0);
    chk(cap_data == 0, "R1 data in reset", cap_data, 64'd0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk); #3;
    chk(cap_valid == 0, "R1 valid after reset", {63'd0, cap_valid}, 64'd0);

    // rising on line 3, low bits set to junk (R4 low bits ignored)
    @(negedge clk); cfg_word = mk_cfg(1, 1, 3, 8'hA5);
    repeat (2) @(negedge clk);
    drive_and_stamp(3, 1, st);
    chk(cap_valid == 1, "R3 rising capture valid", {63'd0, cap_valid}, 64'd1);
    chk(cap_data == st, "R6 capture time", cap_data, st);
    chk(cap_data[31:0] < 32'd1000000000 && cap_data[63:32] == st[63:32], "R5 layout", cap_data, st);
    take();
    chk(cap_valid == 0, "R7 cleared by take", {63'd0, cap_valid}, 64'd0);

    // falling edge ignored in rising mode
    drive_and_stamp(3, 0, st);
    chk(cap_valid == 0, "R3 opposite edge ignored", {63'd0, cap_valid}, 64'd0);

    // falling mode
    @(negedge clk); cfg_word = mk_cfg(1, 0, 3, 8'h00);
    drive_and_stamp(3, 1, st);
    chk(cap_valid == 0, "R3 rise ignored in falling mode", {63'd0, cap_valid}, 64'd0);
    drive_and_stamp(3, 0, st);
    chk(cap_valid == 1 && cap_data == st, "R3 falling capture", cap_data, st);
    take();

    // other lines ignored
    drive_and_stamp(4, 1, st);
    drive_and_stamp(4, 0, st);
    drive_and_stamp(63, 1, st);
    drive_and_stamp(63, 0, st);
    chk(cap_valid == 0, "R4 other lines ignored", {63'd0, cap_valid}, 64'd0);

    // highest select index
    @(negedge clk); cfg_word = mk_cfg(1, 1, 63, 8'h00);
    drive_and_stamp(63, 1, st);
    chk(cap_valid == 1 && cap_data == st, "R4 select line 63", cap_data, st);
    keep = cap_data;

    // disarmed: nothing changes
    @(negedge clk); cfg_word = mk_cfg(0, 0, 63, 8'h00);
    drive_and_stamp(63, 0, st);
    chk(cap_valid == 1 && cap_data == keep, "R2 disarmed keeps word", cap_data, keep);
    take();
    @(negedge clk); cfg_word = mk_cfg(0, 1, 63, 8'h00);
    drive_and_stamp(63, 1, st);
    chk(cap_valid == 0, "R2 disarmed no capture", {63'd0, cap_valid}, 64'd0);

    // overwrite without take
    @(negedge clk); cfg_word = mk_cfg(1, 1, 5, 8'h00);
    drive_and_stamp(5, 1, st);
    drive_and_stamp(5, 0, st2);
    drive_and_stamp(5, 1, st2);
    chk(cap_valid == 1 && cap_data == st2 && st2 != st, "R8 overwrite latest", cap_data, st2);

    // take and capture in the same cycle
    drive_and_stamp(5, 0, st);
    @(negedge clk); evt_in[5] = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); #1 st = {tod_sec, tod_nsec}; cap_ready = 1;
    @(posedge clk); @(negedge clk); cap_ready = 0; #3;
    chk(cap_valid == 1 && cap_data == st, "R8 capture beats take", cap_data, st);
    take();

    // select switch with differing levels: line 5 high, line 6 low
    @(negedge clk); cfg_word = mk_cfg(1, 1, 6, 8'h00);
    repeat (4) @(negedge clk);
    @(negedge clk); cfg_word = mk_cfg(1, 1, 5, 8'h00);
    repeat (4) @(negedge clk); #3;
    chk(cap_valid == 0, "R9 select switch no capture", {63'd0, cap_valid}, 64'd0);
    @(negedge clk); cfg_word = mk_cfg(1, 0, 6, 8'h00);
    repeat (4) @(negedge clk); #3;
    chk(cap_valid == 0, "R9 switch back no capture", {63'd0, cap_valid}, 64'd0);

    // capture straddling a seconds rollover
    @(negedge clk); cfg_word = mk_cfg(1, 1, 7, 8'h00);
    @(posedge clk); ld_sec = 32'd41; ld_nsec = 32'd999999986; ld_req = 1;
    drive_and_stamp(7, 1, st);
    chk(cap_data == st, "R5 rollover pair", cap_data, st);
    chk(cap_data == {32'd42, 32'd0} || cap_data == {32'd41, 32'd999999993} ||
        cap_data == {32'd42, 32'd7}, "R5 rollover consistent", cap_data, st);
    take();

    repeat (5) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule